// File: doc/BRIEF.md
# Sector Protection Bit Manager

This block keeps the write-protection state of an eight-sector memory and rules on every program or erase request. Each sector has a persistent protection bit and a dynamic protection bit. A sector is protected when either of its bits is set. One global lock bit covers all sectors at once: while the lock is low, no persistent bit can change. Dynamic bits and the lock are volatile and are lost on reset. Persistent bits are not cleared by reset. They start erased and only an explicit erase-all command clears them.

Commands arrive one per cycle with a sector address. A program or erase request to an unprotected sector produces a one-cycle allow pulse. A request to a protected sector is dropped and produces a one-cycle deny pulse. After a deny, the block holds a status-poll phase for a fixed number of cycles and then returns to read mode. Status-read commands return one protection bit for the addressed sector.

When password mode is active, the lock comes out of reset low. The only way to raise it is an external unlock pulse, which stands for a successful password match. Outside password mode, only a reset raises the lock.

Top module: `sp_manager`

## Requirements
- R1: Once reset is released with `pw_mode_i` low, every dynamic bit reads 0 and the lock reads 1. Until a command arrives, `allow_o`, `deny_o`, `reject_o`, `rd_valid_o`, `rd_data_o` and `poll_o` are all 0.
- R2: Once reset is released with `pw_mode_i` high, the lock reads 0. A one-cycle `pw_unlock_i` pulse while `pw_mode_i` is high sets the lock to 1. In password mode, a lock that was lowered by command can be raised again by the same pulse.
- R3: Opcode 5 lowers the lock to 0. Outside password mode, `pw_unlock_i` has no effect, and the lock stays 0 until the next reset.
- R4: While the lock is 0, opcode 1 (set persistent bit) and opcode 2 (erase all persistent bits) leave the persistent bits unchanged. One cycle after either command, `reject_o` is 1 for exactly one cycle.
- R5: While the lock is 1, opcode 1 sets the persistent bit of the addressed sector and opcode 2 clears every persistent bit. Neither command raises `reject_o`. A reset does not change any persistent bit.
- R6: Opcode 3 sets and opcode 4 clears the dynamic bit of the addressed sector, whatever the state of the lock.
- R7: Opcode 9 (program) and opcode 10 (erase) produce, one cycle later, `allow_o`=1 if the addressed sector has neither bit set, or `deny_o`=1 if it has either bit set. Only one of `allow_o`, `deny_o`, `reject_o` and `rd_valid_o` is ever 1 at a time.
- R8: A deny raises `poll_o` in the same cycle as `deny_o`, and `poll_o` stays 1 for exactly POLL_CYCLES (default 4) cycles. Any command presented while `poll_o` is 1 is ignored. The first command presented after `poll_o` falls is accepted.
- R9: Opcode 6 reads the dynamic bit, opcode 7 reads the persistent bit, and opcode 8 reads the lock level. For opcodes 6 and 7, 1 means protected. For opcode 8, 0 means locked. The bit appears on `rd_data_o` with `rd_valid_o`=1 one cycle after the command. When `rd_valid_o` is 0, `rd_data_o` is 0.
- R10: Opcodes 0 and 11 to 15 change no state and produce no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pw_mode_i | input | 1 | Password mode active |
| pw_unlock_i | input | 1 | Unlock pulse after a password match |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 4 | Command opcode |
| cmd_sect_i | input | 3 | Sector address |
| allow_o | output | 1 | Program or erase permitted (pulse) |
| deny_o | output | 1 | Program or erase dropped (pulse) |
| reject_o | output | 1 | Persistent-bit command refused under lock (pulse) |
| rd_valid_o | output | 1 | Status read data valid |
| rd_data_o | output | 1 | Status read bit |
| poll_o | output | 1 | Status-poll phase after a deny |

## Verification
The hardest situation to reach from the ports is persistent state that must survive a reset while the volatile state around it is wiped. To get there, the stimulus first sets a persistent bit and a dynamic bit and lowers the lock. It then pulses reset, and status reads show the persistent bit still set while the dynamic bit and the lock have returned to their reset values. The password-mode path is reached the same way: the mode flag is held high across a reset, and the bench then checks that the lock can be lowered and raised repeatedly through command and pulse.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_NOP         = 4'd0,
    OP_PPB_SET     = 4'd1,
    OP_PPB_CLR_ALL = 4'd2,
    OP_DYB_SET     = 4'd3,
    OP_DYB_CLR     = 4'd4,
    OP_LOCK_SET    = 4'd5,
    OP_RD_DYB      = 4'd6,
    OP_RD_PPB      = 4'd7,
    OP_RD_LOCK     = 4'd8,
    OP_PROG        = 4'd9,
    OP_ERASE       = 4'd10
  } sp_op_e;
endpackage

// File: rtl/sp_lock_ctrl.sv
module sp_lock_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pw_mode_i,
  input  logic pw_unlock_i,
  input  logic lock_set_i,
  output logic lock_n_o
);
  logic lock_set_q;
  logic unlocked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_set_q <= 1'b0;
      unlocked_q <= 1'b0;
    end else if (pw_unlock_i && pw_mode_i) begin
      lock_set_q <= 1'b0;
      unlocked_q <= 1'b1;
    end else if (lock_set_i) begin
      lock_set_q <= 1'b1;
    end
  end

  // active low: password mode holds lock until first unlock
  assign lock_n_o = ~(lock_set_q | (pw_mode_i & ~unlocked_q));

  // R3: outside password mode nothing raises a lowered lock
  a_r3_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pw_mode_i && !lock_n_o) |=> !lock_n_o);
endmodule

// File: rtl/sp_prot_array.sv
module sp_prot_array #(
  parameter int unsigned NUM_SECT = 8,
  localparam int unsigned SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lock_n_i,
  input  logic [SECT_W-1:0]   sect_i,
  input  logic                ppb_set_i,
  input  logic                ppb_clr_all_i,
  input  logic                dyb_set_i,
  input  logic                dyb_clr_i,
  output logic [NUM_SECT-1:0] ppb_o,
  output logic [NUM_SECT-1:0] dyb_o
);
  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    logic hit;
    logic ppb_bit = 1'b0;  // non-volatile: erased state, no reset
    logic dyb_bit;

    assign hit = (sect_i == SECT_W'(s));

    always_ff @(posedge clk_i) begin
      if (ppb_clr_all_i)          ppb_bit <= 1'b0;
      else if (ppb_set_i && hit)  ppb_bit <= 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                dyb_bit <= 1'b0;
      else if (dyb_set_i && hit)  dyb_bit <= 1'b1;
      else if (dyb_clr_i && hit)  dyb_bit <= 1'b0;
    end

    assign ppb_o[s] = ppb_bit;
    assign dyb_o[s] = dyb_bit;
  end

  // R4: persistent bits frozen while locked
  a_r4_ppb_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_n_i |=> $stable(ppb_o));
endmodule

// File: rtl/sp_req_judge.sv
module sp_req_judge
  import sp_pkg::*;
#(
  parameter int unsigned NUM_SECT    = 8,
  parameter int unsigned POLL_CYCLES = 4,
  localparam int unsigned SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1,
  localparam int unsigned POLL_W = $clog2(POLL_CYCLES + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [OP_W-1:0]     cmd_op_i,
  input  logic [SECT_W-1:0]   cmd_sect_i,
  input  logic                lock_n_i,
  input  logic [NUM_SECT-1:0] ppb_i,
  input  logic [NUM_SECT-1:0] dyb_i,
  output logic                ppb_set_o,
  output logic                ppb_clr_all_o,
  output logic                dyb_set_o,
  output logic                dyb_clr_o,
  output logic                lock_set_o,
  output logic                allow_o,
  output logic                deny_o,
  output logic                reject_o,
  output logic                rd_valid_o,
  output logic                rd_data_o,
  output logic                poll_o
);
  logic [POLL_W-1:0] poll_cnt_q;
  logic accept, is_pe, is_ppb_cmd, is_rd, rd_bit, prot;
  logic allow_d, deny_d, reject_d;

  assign accept = cmd_valid_i && (poll_cnt_q == '0);
  assign prot   = ppb_i[cmd_sect_i] | dyb_i[cmd_sect_i];

  always_comb begin
    is_pe      = 1'b0;
    is_ppb_cmd = 1'b0;
    is_rd      = 1'b0;
    rd_bit     = 1'b0;
    lock_set_o = 1'b0;
    dyb_set_o  = 1'b0;
    dyb_clr_o  = 1'b0;
    case (cmd_op_i)
      OP_PPB_SET, OP_PPB_CLR_ALL: is_ppb_cmd = accept;
      OP_DYB_SET:  dyb_set_o  = accept;
      OP_DYB_CLR:  dyb_clr_o  = accept;
      OP_LOCK_SET: lock_set_o = accept;
      OP_RD_DYB:   begin is_rd = accept; rd_bit = dyb_i[cmd_sect_i]; end
      OP_RD_PPB:   begin is_rd = accept; rd_bit = ppb_i[cmd_sect_i]; end
      OP_RD_LOCK:  begin is_rd = accept; rd_bit = lock_n_i; end
      OP_PROG, OP_ERASE: is_pe = accept;
      default: ;
    endcase
  end

  assign ppb_set_o     = is_ppb_cmd && lock_n_i && (cmd_op_i == OP_PPB_SET);
  assign ppb_clr_all_o = is_ppb_cmd && lock_n_i && (cmd_op_i == OP_PPB_CLR_ALL);
  assign allow_d       = is_pe && !prot;
  assign deny_d        = is_pe && prot;
  assign reject_d      = is_ppb_cmd && !lock_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      allow_o    <= 1'b0;
      deny_o     <= 1'b0;
      reject_o   <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= 1'b0;
      poll_cnt_q <= '0;
    end else begin
      allow_o    <= allow_d;
      deny_o     <= deny_d;
      reject_o   <= reject_d;
      rd_valid_o <= is_rd;
      rd_data_o  <= is_rd && rd_bit;
      if (deny_d)                 poll_cnt_q <= POLL_W'(POLL_CYCLES);
      else if (poll_cnt_q != '0)  poll_cnt_q <= poll_cnt_q - 1'b1;
    end
  end

  assign poll_o = (poll_cnt_q != '0);

  // R7: at most one result pulse per cycle
  a_r7_one_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({allow_o, deny_o, reject_o, rd_valid_o}));
  // R8: deny coincides with poll phase
  a_r8_deny_polls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |-> poll_o);
  // R8: commands during poll produce nothing
  a_r8_poll_ignores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (poll_o && cmd_valid_i) |=> !(allow_o || deny_o || reject_o || rd_valid_o));
  // R9: read data quiet without valid
  a_r9_rd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_o |-> !rd_data_o);
endmodule

// File: rtl/sp_manager.sv
module sp_manager #(
  parameter int unsigned NUM_SECT    = 8,
  parameter int unsigned POLL_CYCLES = 4,
  localparam int unsigned SECT_W = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pw_mode_i,
  input  logic              pw_unlock_i,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_op_i,
  input  logic [SECT_W-1:0] cmd_sect_i,
  output logic              allow_o,
  output logic              deny_o,
  output logic              reject_o,
  output logic              rd_valid_o,
  output logic              rd_data_o,
  output logic              poll_o
);
  logic lock_n, lock_set, ppb_set, ppb_clr_all, dyb_set, dyb_clr;
  logic [NUM_SECT-1:0] ppb, dyb;

  sp_lock_ctrl i_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pw_mode_i   (pw_mode_i),
    .pw_unlock_i (pw_unlock_i),
    .lock_set_i  (lock_set),
    .lock_n_o    (lock_n)
  );

  sp_prot_array #(.NUM_SECT(NUM_SECT)) i_array (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .lock_n_i      (lock_n),
    .sect_i        (cmd_sect_i),
    .ppb_set_i     (ppb_set),
    .ppb_clr_all_i (ppb_clr_all),
    .dyb_set_i     (dyb_set),
    .dyb_clr_i     (dyb_clr),
    .ppb_o         (ppb),
    .dyb_o         (dyb)
  );

  sp_req_judge #(.NUM_SECT(NUM_SECT), .POLL_CYCLES(POLL_CYCLES)) i_judge (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_op_i      (cmd_op_i),
    .cmd_sect_i    (cmd_sect_i),
    .lock_n_i      (lock_n),
    .ppb_i         (ppb),
    .dyb_i         (dyb),
    .ppb_set_o     (ppb_set),
    .ppb_clr_all_o (ppb_clr_all),
    .dyb_set_o     (dyb_set),
    .dyb_clr_o     (dyb_clr),
    .lock_set_o    (lock_set),
    .allow_o       (allow_o),
    .deny_o        (deny_o),
    .reject_o      (reject_o),
    .rd_valid_o    (rd_valid_o),
    .rd_data_o     (rd_data_o),
    .poll_o        (poll_o)
  );
endmodule

// File: tb/test_sp_manager.sv
module test_sp_manager;
  localparam int POLL = 4;
  localparam int NV   = 21;
  // {op, sect, exp allow/deny/reject/rd_valid/rd_data}
  localparam logic [11:0] VEC [NV] = '{
    {4'd8,  3'd0, 5'b00011},  // R9 lock reads 1
    {4'd9,  3'd3, 5'b10000},  // R7 allow
    {4'd3,  3'd3, 5'b00000},  // R6
    {4'd6,  3'd3, 5'b00011},  // R9 dyb
    {4'd9,  3'd3, 5'b01000},  // R7 deny via dyb
    {4'd4,  3'd3, 5'b00000},  // R6
    {4'd10, 3'd3, 5'b10000},  // R7 allow erase
    {4'd1,  3'd5, 5'b00000},  // R5 set ppb
    {4'd7,  3'd5, 5'b00011},  // R9 ppb
    {4'd10, 3'd5, 5'b01000},  // R7 deny via ppb
    {4'd7,  3'd4, 5'b00010},  // R5 neighbour untouched
    {4'd5,  3'd0, 5'b00000},  // R3 lock set
    {4'd8,  3'd0, 5'b00010},  // R3 lock reads 0
    {4'd1,  3'd1, 5'b00100},  // R4 reject
    {4'd2,  3'd0, 5'b00100},  // R4 reject
    {4'd7,  3'd5, 5'b00011},  // R4 ppb kept
    {4'd7,  3'd1, 5'b00010},  // R4 ppb not set
    {4'd3,  3'd1, 5'b00000},  // R6 dyb under lock
    {4'd9,  3'd1, 5'b01000},  // R6 deny
    {4'd15, 3'd2, 5'b00000},  // R10 unknown op
    {4'd9,  3'd2, 5'b10000}   // R10 no state changed
  };

  logic clk = 1'b0, rst_n = 1'b0, pw_mode = 1'b0, pw_unlock = 1'b0;
  logic cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [2:0] cmd_sect = '0;
  logic allow, deny, reject, rd_valid, rd_data, poll;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sp_manager i_sp_manager (
    .clk_i(clk), .rst_ni(rst_n), .pw_mode_i(pw_mode), .pw_unlock_i(pw_unlock),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_sect_i(cmd_sect),
    .allow_o(allow), .deny_o(deny), .reject_o(reject),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .poll_o(poll)
  );

  function automatic logic [4:0] outs();
    return {allow, deny, reject, rd_valid, rd_data};
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // called at a negedge, returns at the negedge where results are visible
  task automatic cmd(input logic [3:0] op, input logic [2:0] s);
    cmd_valid = 1'b1; cmd_op = op; cmd_sect = s;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = '0; cmd_sect = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic unlock_pulse();
    pw_unlock = 1'b1; @(negedge clk); pw_unlock = 1'b0; @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(1);
  endtask

  initial begin
    int n;
    idle(1);
    do_reset();
    check("R1 outputs", {poll, outs()}, 6'b0);
    for (int v = 0; v < NV; v++) begin
      cmd(VEC[v][11:8], VEC[v][7:5]);
      check($sformatf("R7/R9 vec %0d", v), {1'b0, outs()}, {1'b0, VEC[v][4:0]});
      idle(POLL + 1);
    end
    // R3: unlock pulse ignored outside password mode
    unlock_pulse();
    cmd(4'd8, 3'd0);
    check("R3 unlock ignored", {1'b0, outs()}, 6'b000010);
    idle(1);
    // R8: poll length
    cmd(4'd9, 3'd1);
    check("R8 deny+poll", {poll, outs()}, 6'b101000);
    n = 0;
    while (poll && n < 20) begin n++; @(negedge clk); end
    check("R8 poll length", 6'(n), 6'(POLL));
    // R8: command during poll ignored, next accepted
    cmd(4'd9, 3'd1);
    cmd(4'd8, 3'd0);
    check("R8 ignored in poll", {poll, outs()}, 6'b100000);
    while (poll) @(negedge clk);
    cmd(4'd8, 3'd0);
    check("R8 accepted after poll", {poll, outs()}, 6'b000010);
    idle(1);
    // R1/R5: reset clears volatile state, keeps persistent bits
    do_reset();
    check("R1 outputs after reset", {poll, outs()}, 6'b0);
    cmd(4'd8, 3'd0);
    check("R1 lock after reset", {1'b0, outs()}, 6'b000011);
    cmd(4'd6, 3'd1);
    check("R1 dyb cleared", {1'b0, outs()}, 6'b000010);
    cmd(4'd7, 3'd5);
    check("R5 ppb survives reset", {1'b0, outs()}, 6'b000011);
    // R2: password mode
    pw_mode = 1'b1;
    do_reset();
    cmd(4'd8, 3'd0);
    check("R2 locked at reset", {1'b0, outs()}, 6'b000010);
    cmd(4'd1, 3'd2);
    check("R4 reject in pw mode", {1'b0, outs()}, 6'b000100);
    idle(1);
    unlock_pulse();
    cmd(4'd8, 3'd0);
    check("R2 unlocked", {1'b0, outs()}, 6'b000011);
    cmd(4'd1, 3'd2);
    check("R5 ppb set", {1'b0, outs()}, 6'b000000);
    cmd(4'd7, 3'd2);
    check("R5 ppb reads set", {1'b0, outs()}, 6'b000011);
    cmd(4'd5, 3'd0);
    cmd(4'd8, 3'd0);
    check("R3 lock by cmd", {1'b0, outs()}, 6'b000010);
    idle(1);
    unlock_pulse();
    cmd(4'd8, 3'd0);
    check("R2 relock cleared", {1'b0, outs()}, 6'b000011);
    cmd(4'd2, 3'd0);
    check("R5 erase all", {1'b0, outs()}, 6'b000000);
    cmd(4'd7, 3'd5);
    check("R5 ppb erased", {1'b0, outs()}, 6'b000010);
    cmd(4'd10, 3'd2);
    check("R7 allow after erase", {1'b0, outs()}, 6'b010000);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule